// File: doc/BRIEF.md
# Single-Pass Bubble Sort Network

This block carries out one left-to-right bubble pass over a vector of `N` signed elements of `W` bits each. A chain of `N-1` compare-and-swap cells runs across the vector. The first cell takes element 0 on its left side. Every later cell takes, on its left side, the larger result of the cell before it. On its right side, cell `k` takes input element `k+1`. The smaller result of each cell goes to the matching output slot. The larger result of the last cell fills the top slot. One pass therefore moves the largest element to the last position, and everything else shifts as a single bubble sweep dictates.

The network is combinational. A parameter adds an output register stage for timing. With that stage, the result of an input vector shows up one clock after it is presented. Without it, the output follows the input directly. Callers that need a full sort chain several of these passes, or run the data through the block again.

Top module: `bubble_pass_net`

## Requirements
- R1: Element `k` of a vector sits at bits `[k*W +: W]` of `inVec` and `outVec` and is a two's-complement signed value. For any input, `outVec` equals one bubble pass: the carry starts as element 0, and for `k` = 1..N-1 the smaller of (carry, element `k`) goes to output slot `k-1` while the larger becomes the new carry. The final carry goes to slot `N-1`.
- R2: A compare-and-swap cell passes (left, right) through unchanged when left < right under signed comparison. Otherwise it emits (right, left), so negative values order below positive ones.
- R3: Output slot `N-1` always holds the maximum of the input elements.
- R4: An input that is already in non-decreasing order comes out unchanged.
- R5: Equal neighbours are swapped by the strict comparison, which leaves the output values the same as R1 gives. For example, 2,9,1,9 yields 2,1,9,9.
- R6: With the output register enabled (the default), `outVec` takes the pass result of the `inVec` present at a rising clock edge, and holds it until the next edge.
- R7: While `rstN` is low, the output register holds all zeros, whatever `inVec` is.
- R8: With N=4, the input 4,1,2,3 (element 0 first) yields 1,2,3,4.
- R9: The output is a permutation of the input, so the sum of its elements equals the sum of the input elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset that clears the output register |
| inVec | input | N*W | Packed input vector, element 0 in the low bits |
| outVec | output | N*W | Packed vector after one bubble pass |

## Verification
A wrong compare inside one cell shows up as a misplaced value at the ports. It appears in the same cycle as the pass result, which is one clock after the input with the register in place. A signed/unsigned mix-up only shows when negative values appear, and a broken carry chain most often shows as a wrong value in the last slot. Because of this, the vectors stress negative values, ties, reversed and already-ordered inputs, and random vectors checked against a pass model. A register that fails to capture or to clear shows up one edge late, as a stale or non-zero vector.

// File: rtl/bsort_pkg.sv
package bsort_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // load the output register at this edge
    logic bypass;   // drive the output straight from the chain
  } passStrobe_t;
endpackage

// File: rtl/cas_cell.sv
module cas_cell #(
  parameter int W = 8
) (
  input  logic signed [W-1:0] leftIn,
  input  logic signed [W-1:0] rightIn,
  output logic signed [W-1:0] lowOut,
  output logic signed [W-1:0] highOut
);
  logic keepOrder;

  always_comb begin
    keepOrder = leftIn < rightIn;
    if (keepOrder) begin
      lowOut  = leftIn;
      highOut = rightIn;
    end else begin
      lowOut  = rightIn;
      highOut = leftIn;
    end
  end

  always_comb begin
    if (!$isunknown({leftIn, rightIn})) begin
      AST_CAS_ORDER: assert (lowOut <= highOut); // R2
    end
  end
endmodule

// File: rtl/pass_ctrl.sv
module pass_ctrl
  import bsort_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        rstN,
  output passStrobe_t strobes
);
  generate
    if (REG_OUT) begin : g_reg
      always_comb begin
        strobes.capture = rstN;
        strobes.bypass  = 1'b0;
      end
    end else begin : g_comb
      always_comb begin
        strobes.capture = 1'b0;
        strobes.bypass  = 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/pass_datapath.sv
module pass_datapath
  import bsort_pkg::*;
#(
  parameter int N       = 4,
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rstN,
  input  passStrobe_t    strobes,
  input  logic [N*W-1:0] inVec,
  output logic [N*W-1:0] outVec
);
  localparam int NCELL = N - 1;
  localparam int SUMW  = W + $clog2(N) + 1;

  logic signed [W-1:0] elemIn [N];
  logic signed [W-1:0] carry  [N];
  logic signed [W-1:0] lowOut [NCELL];
  logic [N*W-1:0]      combOut;

  generate
    for (genvar e = 0; e < N; e++) begin : g_unpack
      assign elemIn[e] = inVec[e*W +: W];
    end
  endgenerate

  assign carry[0] = elemIn[0];

  generate
    for (genvar k = 0; k < NCELL; k++) begin : g_cell
      cas_cell #(.W(W)) u_cell (
        .leftIn  (carry[k]),
        .rightIn (elemIn[k+1]),
        .lowOut  (lowOut[k]),
        .highOut (carry[k+1])
      );
      assign combOut[k*W +: W] = lowOut[k];
    end
  endgenerate

  assign combOut[NCELL*W +: W] = carry[NCELL];

  generate
    if (REG_OUT) begin : g_outReg
      logic [N*W-1:0] outReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                outReg <= '0;
        else if (strobes.capture) outReg <= combOut;
      end
      assign outVec = strobes.bypass ? combOut : outReg;

      for (genvar g = 0; g < N; g++) begin : g_maxChk
        AST_REG_MAX: assert property (@(posedge clk) disable iff (!rstN)
          1'b1 |=> ($signed(outVec[NCELL*W +: W]) >= $signed($past(inVec[g*W +: W])))); // R6
      end
      AST_RESET_ZERO: assert property (@(posedge clk)
        !rstN |-> (outVec == '0)); // R7
    end else begin : g_noReg
      assign outVec = combOut;
    end
  endgenerate

  // checks on the chain result against the raw input
  always_comb begin
    logic signed [SUMW-1:0] sumIn;
    logic signed [SUMW-1:0] sumOut;
    logic                   isSorted;
    sumIn    = '0;
    sumOut   = '0;
    isSorted = 1'b1;
    for (int i = 0; i < N; i++) begin
      sumIn  = sumIn  + SUMW'(elemIn[i]);
      sumOut = sumOut + SUMW'($signed(combOut[i*W +: W]));
      if (i > 0 && elemIn[i-1] > elemIn[i]) isSorted = 1'b0;
    end
    if (!$isunknown(inVec)) begin
      AST_SUM_KEPT: assert (sumIn == sumOut); // R9
      if (isSorted) begin
        AST_SORTED_SAME: assert (combOut == inVec); // R4
      end
      for (int i = 0; i < N; i++) begin
        AST_MAX_LAST: assert ($signed(combOut[NCELL*W +: W]) >= elemIn[i]); // R3
      end
    end
  end
endmodule

// File: rtl/bubble_pass_net.sv
module bubble_pass_net
  import bsort_pkg::*;
#(
  parameter int N       = 4,
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [N*W-1:0] inVec,
  output logic [N*W-1:0] outVec
);
  passStrobe_t strobes;

  initial begin
    AST_N_MIN: assert (N >= 2); // R1
  end

  pass_ctrl #(.REG_OUT(REG_OUT)) u_ctrl (
    .rstN    (rstN),
    .strobes (strobes)
  );

  pass_datapath #(.N(N), .W(W), .REG_OUT(REG_OUT)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .inVec   (inVec),
    .outVec  (outVec)
  );
endmodule

// File: tb/sim_bubble_pass_net.sv
module sim_bubble_pass_net;
  localparam int N = 4;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int NTAB = 7;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [N*W-1:0] inVec = '0;
  logic [N*W-1:0] outVec;
  int nChecks = 0;
  int nFails  = 0;

  // element 0 first in each row
  localparam logic signed [W-1:0] TAB_IN [NTAB][N] = '{
    '{8'sd4,    8'sd1,    8'sd2,  8'sd3},
    '{8'sd1,    8'sd2,    8'sd3,  8'sd4},
    '{8'sd4,    8'sd3,    8'sd2,  8'sd1},
    '{-8'sd1,   8'sd5,   -8'sd7,  8'sd2},
    '{8'sd3,    8'sd3,    8'sd3,  8'sd3},
    '{8'sd127, -8'sd128,  8'sd0,  8'sd0},
    '{8'sd2,    8'sd9,    8'sd1,  8'sd9}
  };
  localparam logic signed [W-1:0] TAB_EXP [NTAB][N] = '{
    '{8'sd1,    8'sd2,    8'sd3,  8'sd4},
    '{8'sd1,    8'sd2,    8'sd3,  8'sd4},
    '{8'sd3,    8'sd2,    8'sd1,  8'sd4},
    '{-8'sd1,  -8'sd7,    8'sd2,  8'sd5},
    '{8'sd3,    8'sd3,    8'sd3,  8'sd3},
    '{-8'sd128, 8'sd0,    8'sd0,  8'sd127},
    '{8'sd2,    8'sd1,    8'sd9,  8'sd9}
  };

  bubble_pass_net #(.N(N), .W(W), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .inVec(inVec), .outVec(outVec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [N*W-1:0] onePass(input logic [N*W-1:0] v);
    logic [N*W-1:0]      r;
    logic signed [W-1:0] c;
    logic signed [W-1:0] e;
    r = '0;
    c = v[0 +: W];
    for (int k = 1; k < N; k++) begin
      e = v[k*W +: W];
      if (c < e) begin
        r[(k-1)*W +: W] = c;
        c = e;
      end else begin
        r[(k-1)*W +: W] = e;
      end
    end
    r[(N-1)*W +: W] = c;
    return r;
  endfunction

  task automatic check(input string req, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic applyAndWait(input logic [N*W-1:0] v);
    inVec = v;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChecks + 1 - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    logic [N*W-1:0] v;
    logic [N*W-1:0] prevExp;
    logic signed [W-1:0] mx;
    logic signed [W-1:0] a [N];
    logic signed [W-1:0] t;

    // R7: reset state with live input
    inVec = {8'sd9, 8'sd7, 8'sd5, 8'sd3};
    repeat (3) @(negedge clk);
    check("R7 reset clears output", outVec, '0);

    @(negedge clk);
    rstN = 1'b1;

    // R1 R2 R4 R5 R8: table walk
    for (int i = 0; i < NTAB; i++) begin
      logic [N*W-1:0] tin;
      logic [N*W-1:0] texp;
      for (int k = 0; k < N; k++) begin
        tin[k*W +: W]  = TAB_IN[i][k];
        texp[k*W +: W] = TAB_EXP[i][k];
      end
      applyAndWait(tin);
      if (i == 0) check("R8 4,1,2,3 pass", outVec, texp);
      else        check("R1 R2 R5 table pass", outVec, texp);
    end

    // R1 R3: random vectors against the pass model
    for (int i = 0; i < 40; i++) begin
      v = {$urandom, $urandom};
      v = v[N*W-1:0];
      applyAndWait(v);
      check("R1 random pass", outVec, onePass(v));
      mx = v[0 +: W];
      for (int k = 1; k < N; k++)
        if ($signed(v[k*W +: W]) > mx) mx = v[k*W +: W];
      check("R3 max in last slot", {{((N-1)*W){1'b0}}, outVec[(N-1)*W +: W]},
            {{((N-1)*W){1'b0}}, mx});
    end

    // R4: ordered random inputs stay unchanged
    for (int i = 0; i < 10; i++) begin
      for (int k = 0; k < N; k++) a[k] = W'($urandom);
      for (int p = 1; p < N; p++)
        for (int q = p; q > 0; q--)
          if (a[q-1] > a[q]) begin t = a[q]; a[q] = a[q-1]; a[q-1] = t; end
      for (int k = 0; k < N; k++) v[k*W +: W] = a[k];
      applyAndWait(v);
      check("R4 sorted unchanged", outVec, v);
    end

    // R6: latency of one edge and hold between edges
    v = {8'sd1, 8'sd2, 8'sd3, 8'sd4};
    applyAndWait(v);
    prevExp = onePass(v);
    inVec = {-8'sd5, 8'sd6, -8'sd7, 8'sd8};
    #1;
    check("R6 output held before edge", outVec, prevExp);
    @(negedge clk);
    check("R6 output after one edge", outVec, onePass(inVec));
    @(negedge clk);
    check("R6 output stable with stable input", outVec, onePass(inVec));

    // R7: reset again mid-run
    rstN = 1'b0;
    #1;
    check("R7 async clear", outVec, '0);
    @(negedge clk);
    check("R7 held clear under reset", outVec, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R6 capture after reset", outVec, onePass(inVec));

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule